// File: doc/BRIEF.md
# Reservation Station with Result-Bus Wakeup

This block holds a few instructions that wait to run on one functional unit. It also keeps the register file and a per-register status table that names the pending producer of each register. An in-order dispatcher offers one instruction per cycle: an opcode, a destination register and two source registers. The block accepts it only while one of its entries is empty. Each source is resolved at dispatch. If the register has no pending producer, its value is copied from the register file. Otherwise the entry keeps the producer's tag and waits. The destination register is then re-tagged with the new entry's tag, so later readers point at this entry rather than at the register.

Results come back on a shared result bus that carries a tag and a value. Every waiting operand whose tag matches takes the value. The register whose status still names that tag takes the value and drops back to "no producer". The entry with that tag becomes free. When one or more entries hold both operands, the oldest of them is offered to the functional unit. It leaves when the unit signals that it is free. An entry is issued only once and stays allocated until its own result appears on the bus.

Top module: `resv_station`

## Requirements
- R1: `disp_ready` is high exactly when at least one entry is empty at the start of the cycle. An entry freed by a broadcast in the same cycle does not count. A dispatch (`disp_valid` with `disp_ready`) fills the lowest-numbered empty entry, and that entry's tag is its index plus one. When `disp_ready` is low, `disp_valid` changes nothing.
- R2: A source whose register has no pending producer is captured from the register file at dispatch.
- R3: After a dispatch, the status of the destination register reads back (`rf_rtag`) as the new entry's tag. A status of zero means no pending write.
- R4: A waiting operand takes `cdb_value` in the cycle in which `cdb_valid` is high and `cdb_tag` equals the tag it holds.
- R5: If a source's producer broadcasts in the same cycle as the dispatch that reads it, the new entry takes the bus value directly and does not wait.
- R6: `issue_valid` is high only while some allocated, not-yet-issued entry has both operands. The entry is issued when `fu_ready` is also high and is never offered again.
- R7: When several entries are ready, the one dispatched earliest is offered. Ages saturate after 2^AGE_W-1 cycles, and equal ages go to the lower index.
- R8: A broadcast frees the entry with that tag. It writes `cdb_value` into every register whose status equals the tag and clears that status, unless a dispatch in the same cycle re-tags the register, in which case the new tag is kept. After all work drains, every register holds the value of its last writer in dispatch order.
- R9: After reset every entry is empty, `issue_valid` is low, and every register reads value zero and tag zero.
- R10: A broadcast with `cdb_tag` zero is ignored. It frees nothing, wakes nothing and writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | An entry is free; dispatch is accepted |
| disp_op | input | OP_W | Opcode carried to the functional unit |
| disp_dst | input | RA_W | Destination register |
| disp_src_a | input | RA_W | First source register |
| disp_src_b | input | RA_W | Second source register |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Tag of the producing entry (zero = none) |
| cdb_value | input | DATA_W | Result value |
| fu_ready | input | 1 | Functional unit can take an instruction this cycle |
| issue_valid | output | 1 | A ready entry is offered |
| issue_tag | output | TAG_W | Tag of the offered entry |
| issue_op | output | OP_W | Opcode of the offered entry |
| issue_opnd_a | output | DATA_W | First operand of the offered entry |
| issue_opnd_b | output | DATA_W | Second operand of the offered entry |
| rf_raddr | input | RA_W | Register read address |
| rf_rdata | output | DATA_W | Register value at `rf_raddr` |
| rf_rtag | output | TAG_W | Pending producer tag of `rf_raddr` |

## Verification
The issue outputs, `disp_ready` and the register read port are combinational views of registered state. A dispatch, broadcast or issue made in one cycle shows up in the next cycle: the new entry may already be offered then, a woken operand counts as ready, and the register value and status are updated. The bench drives inputs on the falling edge and applies each cycle's effects to its reference model right away. On the next falling edge it compares the outputs with that model, so every result is checked exactly one clock after its cause. The broadcast carries the value that the bench's in-order reference computes from the opcode and the operands each instruction read at dispatch. The final register contents are checked after a drain with no dispatches.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Default geometry shared by the station and its bench-facing checker.
  localparam int RS_ENTRIES_DEF = 4;
  localparam int RS_REGS_DEF    = 8;
  localparam int RS_DATA_W_DEF  = 16;
  localparam int RS_OP_W_DEF    = 2;
  localparam int RS_AGE_W_DEF   = 8;
endpackage

// File: rtl/rs_pick_free.sv
// Finds the lowest-numbered empty entry.
module rs_pick_free #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  busy,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rs_pick_oldest.sv
// Among ready entries, selects the largest age; ties go to the lower index.
module rs_pick_oldest #(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int IW = 2
) (
  input  logic [N-1:0]  ready,
  input  logic [AW-1:0] age [N],
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [AW-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (ready[i] && (!found || age[i] > best)) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = age[i];
      end
    end
  end
endmodule

// File: rtl/rs_regstat.sv
// Register values plus the pending-producer table used for renaming.
module rs_regstat #(
  parameter int NREGS = 8,
  parameter int DW    = 16,
  parameter int TW    = 3,
  parameter int RAW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cdb_valid,
  input  logic [TW-1:0]  cdb_tag,
  input  logic [DW-1:0]  cdb_value,
  input  logic           set_en,
  input  logic [RAW-1:0] set_reg,
  input  logic [TW-1:0]  set_tag,
  input  logic [RAW-1:0] ra_a,
  input  logic [RAW-1:0] ra_b,
  input  logic [RAW-1:0] ra_dbg,
  output logic [TW-1:0]  tag_a,
  output logic [DW-1:0]  val_a,
  output logic [TW-1:0]  tag_b,
  output logic [DW-1:0]  val_b,
  output logic [TW-1:0]  tag_dbg,
  output logic [DW-1:0]  val_dbg
);
  logic [TW-1:0] stat_q [NREGS];
  logic [TW-1:0] stat_d [NREGS];
  logic [DW-1:0] rf_q   [NREGS];
  logic [NREGS-1:0] rf_we;

  always_comb begin
    for (int r = 0; r < NREGS; r++) begin
      rf_we[r]  = cdb_valid && (cdb_tag != '0) && (stat_q[r] == cdb_tag);
      stat_d[r] = rf_we[r] ? '0 : stat_q[r];
      if (set_en && set_reg == RAW'(r)) stat_d[r] = set_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) begin
        stat_q[r] <= '0;
        rf_q[r]   <= '0;
      end
    end else begin
      for (int r = 0; r < NREGS; r++) begin
        stat_q[r] <= stat_d[r];
        if (rf_we[r]) rf_q[r] <= cdb_value;
      end
    end
  end

  assign tag_a   = stat_q[ra_a];
  assign val_a   = rf_q[ra_a];
  assign tag_b   = stat_q[ra_b];
  assign val_b   = rf_q[ra_b];
  assign tag_dbg = stat_q[ra_dbg];
  assign val_dbg = rf_q[ra_dbg];
endmodule

// File: rtl/resv_station.sv
module resv_station
  import rs_pkg::*;
#(
  parameter int NUM_RS   = RS_ENTRIES_DEF,
  parameter int NUM_REGS = RS_REGS_DEF,
  parameter int DATA_W   = RS_DATA_W_DEF,
  parameter int OP_W     = RS_OP_W_DEF,
  parameter int AGE_W    = RS_AGE_W_DEF,
  parameter int TAG_W    = $clog2(NUM_RS + 1),
  parameter int RA_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [OP_W-1:0]   disp_op,
  input  logic [RA_W-1:0]   disp_dst,
  input  logic [RA_W-1:0]   disp_src_a,
  input  logic [RA_W-1:0]   disp_src_b,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              fu_ready,
  output logic              issue_valid,
  output logic [TAG_W-1:0]  issue_tag,
  output logic [OP_W-1:0]   issue_op,
  output logic [DATA_W-1:0] issue_opnd_a,
  output logic [DATA_W-1:0] issue_opnd_b,
  input  logic [RA_W-1:0]   rf_raddr,
  output logic [DATA_W-1:0] rf_rdata,
  output logic [TAG_W-1:0]  rf_rtag
);
  localparam int IW = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

  // Entry state
  logic [NUM_RS-1:0] busy_q, busy_d, issued_q, issued_d, ready;
  logic [OP_W-1:0]   op_q    [NUM_RS];
  logic [OP_W-1:0]   op_d    [NUM_RS];
  logic [TAG_W-1:0]  tag_a_q [NUM_RS];
  logic [TAG_W-1:0]  tag_a_d [NUM_RS];
  logic [TAG_W-1:0]  tag_b_q [NUM_RS];
  logic [TAG_W-1:0]  tag_b_d [NUM_RS];
  logic [DATA_W-1:0] val_a_q [NUM_RS];
  logic [DATA_W-1:0] val_a_d [NUM_RS];
  logic [DATA_W-1:0] val_b_q [NUM_RS];
  logic [DATA_W-1:0] val_b_d [NUM_RS];
  logic [AGE_W-1:0]  age_q   [NUM_RS];
  logic [AGE_W-1:0]  age_d   [NUM_RS];

  logic              alloc_found, pick_found, disp_fire, issue_fire;
  logic [IW-1:0]     alloc_idx, pick_idx;
  logic [TAG_W-1:0]  alloc_tag;
  logic [TAG_W-1:0]  rs_tag_a, rs_tag_b, nt_a, nt_b;
  logic [DATA_W-1:0] rs_val_a, rs_val_b, nv_a, nv_b;

  // Source resolution at dispatch: register value, same-cycle bus value, or wait on tag.
  function automatic logic [TAG_W+DATA_W-1:0] resolve(
    input logic [TAG_W-1:0]  st,
    input logic [DATA_W-1:0] rv,
    input logic              bv,
    input logic [TAG_W-1:0]  bt,
    input logic [DATA_W-1:0] bd
  );
    if (st == '0)            return {{TAG_W{1'b0}}, rv};
    else if (bv && bt == st) return {{TAG_W{1'b0}}, bd};
    else                     return {st, {DATA_W{1'b0}}};
  endfunction

  rs_pick_free #(.N(NUM_RS), .IW(IW)) u_free (
    .busy (busy_q),
    .found(alloc_found),
    .idx  (alloc_idx)
  );

  rs_pick_oldest #(.N(NUM_RS), .AW(AGE_W), .IW(IW)) u_pick (
    .ready(ready),
    .age  (age_q),
    .found(pick_found),
    .idx  (pick_idx)
  );

  rs_regstat #(.NREGS(NUM_REGS), .DW(DATA_W), .TW(TAG_W), .RAW(RA_W)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .cdb_valid(cdb_valid),
    .cdb_tag  (cdb_tag),
    .cdb_value(cdb_value),
    .set_en   (disp_fire),
    .set_reg  (disp_dst),
    .set_tag  (alloc_tag),
    .ra_a     (disp_src_a),
    .ra_b     (disp_src_b),
    .ra_dbg   (rf_raddr),
    .tag_a    (rs_tag_a),
    .val_a    (rs_val_a),
    .tag_b    (rs_tag_b),
    .val_b    (rs_val_b),
    .tag_dbg  (rf_rtag),
    .val_dbg  (rf_rdata)
  );

  assign disp_ready = alloc_found;
  assign disp_fire  = disp_valid && alloc_found;
  assign alloc_tag  = TAG_W'(alloc_idx) + TAG_W'(1);
  assign issue_fire = pick_found && fu_ready;
  assign {nt_a, nv_a} = resolve(rs_tag_a, rs_val_a, cdb_valid, cdb_tag, cdb_value);
  assign {nt_b, nv_b} = resolve(rs_tag_b, rs_val_b, cdb_valid, cdb_tag, cdb_value);

  always_comb begin
    for (int i = 0; i < NUM_RS; i++) begin
      ready[i] = busy_q[i] && !issued_q[i] && (tag_a_q[i] == '0) && (tag_b_q[i] == '0);
    end
  end

  // Next-state logic for all entries
  always_comb begin
    busy_d   = busy_q;
    issued_d = issued_q;
    op_d     = op_q;
    tag_a_d  = tag_a_q;
    tag_b_d  = tag_b_q;
    val_a_d  = val_a_q;
    val_b_d  = val_b_q;
    age_d    = age_q;
    for (int i = 0; i < NUM_RS; i++) begin
      if (busy_q[i] && age_q[i] != '1) age_d[i] = age_q[i] + AGE_W'(1);
      if (cdb_valid && tag_a_q[i] != '0 && tag_a_q[i] == cdb_tag) begin
        tag_a_d[i] = '0;
        val_a_d[i] = cdb_value;
      end
      if (cdb_valid && tag_b_q[i] != '0 && tag_b_q[i] == cdb_tag) begin
        tag_b_d[i] = '0;
        val_b_d[i] = cdb_value;
      end
      if (issue_fire && pick_idx == IW'(i)) issued_d[i] = 1'b1;
      if (cdb_valid && cdb_tag == TAG_W'(i + 1)) begin
        busy_d[i]   = 1'b0;
        issued_d[i] = 1'b0;
      end
      if (disp_fire && alloc_idx == IW'(i)) begin
        busy_d[i]   = 1'b1;
        issued_d[i] = 1'b0;
        op_d[i]     = disp_op;
        age_d[i]    = '0;
        tag_a_d[i]  = nt_a;
        val_a_d[i]  = nv_a;
        tag_b_d[i]  = nt_b;
        val_b_d[i]  = nv_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= '0;
      issued_q <= '0;
      for (int i = 0; i < NUM_RS; i++) begin
        op_q[i]    <= '0;
        tag_a_q[i] <= '0;
        tag_b_q[i] <= '0;
        val_a_q[i] <= '0;
        val_b_q[i] <= '0;
        age_q[i]   <= '0;
      end
    end else begin
      busy_q   <= busy_d;
      issued_q <= issued_d;
      op_q     <= op_d;
      tag_a_q  <= tag_a_d;
      tag_b_q  <= tag_b_d;
      val_a_q  <= val_a_d;
      val_b_q  <= val_b_d;
      age_q    <= age_d;
    end
  end

  assign issue_valid  = pick_found;
  assign issue_tag    = TAG_W'(pick_idx) + TAG_W'(1);
  assign issue_op     = op_q[pick_idx];
  assign issue_opnd_a = val_a_q[pick_idx];
  assign issue_opnd_b = val_b_q[pick_idx];
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int NUM_RS   = 4,
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  parameter int RA_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [RA_W-1:0]   disp_dst,
  input logic              cdb_valid,
  input logic [TAG_W-1:0]  cdb_tag,
  input logic [DATA_W-1:0] cdb_value,
  input logic              fu_ready,
  input logic              issue_valid,
  input logic [TAG_W-1:0]  issue_tag,
  input logic [RA_W-1:0]   rf_raddr,
  input logic [DATA_W-1:0] rf_rdata,
  input logic [TAG_W-1:0]  rf_rtag,
  input logic [NUM_RS-1:0] busy_q,
  input logic [NUM_RS-1:0] issued_q,
  input logic [TAG_W-1:0]  tag_a_q [NUM_RS],
  input logic [TAG_W-1:0]  tag_b_q [NUM_RS],
  input logic [DATA_W-1:0] val_a_q [NUM_RS],
  input logic [DATA_W-1:0] val_b_q [NUM_RS]
);
  localparam int IW = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

  logic [IW-1:0] iss_ix;
  logic          disp_fire;
  assign iss_ix    = IW'(issue_tag - TAG_W'(1));
  assign disp_fire = disp_valid && disp_ready;

  // R6: the offered entry is allocated, not issued, and holds both operands
  a_r6_offer_ready: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (busy_q[iss_ix] && !issued_q[iss_ix] &&
                     tag_a_q[iss_ix] == '0 && tag_b_q[iss_ix] == '0));

  // R6: an accepted entry is not offered again in the next cycle
  a_r6_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && fu_ready) |=> !(issue_valid && issue_tag == $past(issue_tag)));

  // R3: the destination of a dispatch carries a nonzero producer tag afterwards
  a_r3_dst_tagged: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_fire && disp_dst == rf_raddr) |=>
      (rf_raddr != $past(rf_raddr) || rf_rtag != '0));

  // R8: a matching broadcast writes the register and clears its status
  a_r8_status_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && cdb_tag != '0 && rf_rtag == cdb_tag &&
     !(disp_fire && disp_dst == rf_raddr)) |=>
      (rf_raddr != $past(rf_raddr) ||
       (rf_rtag == '0 && rf_rdata == $past(cdb_value))));

  // R4: waiting operands take the matching bus value
  for (genvar e = 0; e < NUM_RS; e++) begin : g_ent
    a_r4_wakeup_a: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q[e] && cdb_valid && tag_a_q[e] != '0 && tag_a_q[e] == cdb_tag) |=>
        (tag_a_q[e] == '0 && val_a_q[e] == $past(cdb_value)));
    a_r4_wakeup_b: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q[e] && cdb_valid && tag_b_q[e] != '0 && tag_b_q[e] == cdb_tag) |=>
        (tag_b_q[e] == '0 && val_b_q[e] == $past(cdb_value)));
  end
endmodule

bind resv_station rs_checker #(
  .NUM_RS  (NUM_RS),
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W),
  .TAG_W   (TAG_W),
  .RA_W    (RA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_valid (disp_valid),
  .disp_ready (disp_ready),
  .disp_dst   (disp_dst),
  .cdb_valid  (cdb_valid),
  .cdb_tag    (cdb_tag),
  .cdb_value  (cdb_value),
  .fu_ready   (fu_ready),
  .issue_valid(issue_valid),
  .issue_tag  (issue_tag),
  .rf_raddr   (rf_raddr),
  .rf_rdata   (rf_rdata),
  .rf_rtag    (rf_rtag),
  .busy_q     (busy_q),
  .issued_q   (issued_q),
  .tag_a_q    (tag_a_q),
  .tag_b_q    (tag_b_q),
  .val_a_q    (val_a_q),
  .val_b_q    (val_b_q)
);

// File: tb/sim_resv_station.sv
module sim_resv_station;
  localparam int CLK_PERIOD = 10;
  localparam int NRS  = 4;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int OPW  = 2;
  localparam int TW   = 3;
  localparam int RAW  = 3;

  logic           clk, rst_n;
  logic           disp_valid, disp_ready;
  logic [OPW-1:0] disp_op;
  logic [RAW-1:0] disp_dst, disp_src_a, disp_src_b;
  logic           cdb_valid;
  logic [TW-1:0]  cdb_tag;
  logic [DW-1:0]  cdb_value;
  logic           fu_ready, issue_valid;
  logic [TW-1:0]  issue_tag;
  logic [OPW-1:0] issue_op;
  logic [DW-1:0]  issue_opnd_a, issue_opnd_b;
  logic [RAW-1:0] rf_raddr;
  logic [DW-1:0]  rf_rdata;
  logic [TW-1:0]  rf_rtag;

  resv_station #(.NUM_RS(NRS), .NUM_REGS(NREG), .DATA_W(DW), .OP_W(OPW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_dst(disp_dst), .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .fu_ready(fu_ready), .issue_valid(issue_valid), .issue_tag(issue_tag),
    .issue_op(issue_op), .issue_opnd_a(issue_opnd_a), .issue_opnd_b(issue_opnd_b),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_rtag(rf_rtag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int  n_chk = 0, n_fail = 0, cyc = 0;
  int  n_byp = 0, n_stall = 0, n_zero = 0;
  bit  done = 0;

  // Reference model, indexed by tag 1..NRS
  bit             m_busy   [NRS+1];
  bit             m_issued [NRS+1];
  bit             m_byp    [NRS+1];
  bit             m_wait   [NRS+1];
  int             m_seq    [NRS+1];
  int             m_due    [NRS+1];
  int             m_pa     [NRS+1];
  int             m_pb     [NRS+1];
  logic [OPW-1:0] m_op     [NRS+1];
  logic [DW-1:0]  m_ga     [NRS+1];
  logic [DW-1:0]  m_gb     [NRS+1];
  logic [DW-1:0]  m_res    [NRS+1];
  int             m_stat   [NREG];
  logic [DW-1:0]  m_rf     [NREG];
  logic [DW-1:0]  g_reg    [NREG];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] alu(input logic [OPW-1:0] op,
                                        input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op)
      2'd0:    return a + b + 16'd1;
      2'd1:    return a - b + 16'd3;
      2'd2:    return a ^ b ^ 16'h5a5a;
      default: return a + (b << 1) + 16'd7;
    endcase
  endfunction

  // One cycle: check outputs at the falling edge, drive inputs, update the model.
  task automatic step(input int p_disp, input int p_fu, input bit allow_disp);
    int cnt, best, t, ct, nt, pa, pb;
    bit fu, want;
    logic [RAW-1:0] d, sa, sb;
    logic [OPW-1:0] op;
    string req;
    cyc++;
    cnt = 0;
    for (int k = 1; k <= NRS; k++) cnt += int'(m_busy[k]);
    chk(disp_ready == (cnt < NRS), "R1", "disp_ready", disp_ready, cnt < NRS);

    best = 0;
    for (int k = 1; k <= NRS; k++)
      if (m_busy[k] && !m_issued[k] && m_pa[k] == 0 && m_pb[k] == 0)
        if (best == 0 || m_seq[k] < m_seq[best]) best = k;
    chk(issue_valid == (best != 0), "R6", "issue_valid", issue_valid, best != 0);
    t = int'(issue_tag);
    if (issue_valid && best != 0) begin
      if (cyc - m_seq[best] < 250)
        chk(t == best, "R7", "oldest tag", t, best);
      if (t >= 1 && t <= NRS) begin
        req = m_byp[t] ? "R5" : (m_wait[t] ? "R4" : "R2");
        chk(issue_op == m_op[t], req, "issue_op", issue_op, m_op[t]);
        chk(issue_opnd_a == m_ga[t], req, "operand a", issue_opnd_a, m_ga[t]);
        chk(issue_opnd_b == m_gb[t], req, "operand b", issue_opnd_b, m_gb[t]);
      end
    end
    chk(int'(rf_rtag) == m_stat[rf_raddr], "R3", "rf_rtag", rf_rtag, m_stat[rf_raddr]);
    chk(rf_rdata == m_rf[rf_raddr], "R8", "rf_rdata", rf_rdata, m_rf[rf_raddr]);

    // Functional unit acceptance
    fu = ($urandom % 100) < p_fu;
    fu_ready = fu;
    if (issue_valid && fu && t >= 1 && t <= NRS) begin
      m_issued[t] = 1;
      m_due[t] = cyc + 1 + int'($urandom % 3);
    end

    // Result bus
    ct = 0;
    for (int k = 1; k <= NRS; k++)
      if (ct == 0 && m_busy[k] && m_issued[k] && m_due[k] > 0 && m_due[k] <= cyc) ct = k;
    if (ct != 0) begin
      cdb_valid = 1; cdb_tag = TW'(ct); cdb_value = m_res[ct];
    end else if ($urandom % 10 == 0) begin
      cdb_valid = 1; cdb_tag = '0; cdb_value = DW'($urandom); n_zero++;  // R10 stimulus
    end else begin
      cdb_valid = 0; cdb_tag = TW'($urandom); cdb_value = DW'($urandom);
    end

    // Dispatch, offered even when full to test that it is ignored (R1)
    want = allow_disp && (($urandom % 100) < p_disp);
    op = OPW'($urandom); d = RAW'($urandom); sa = RAW'($urandom); sb = RAW'($urandom);
    disp_valid = want; disp_op = op; disp_dst = d; disp_src_a = sa; disp_src_b = sb;
    nt = 0;
    if (want && cnt >= NRS) n_stall++;
    if (want && cnt < NRS) begin
      for (int k = NRS; k >= 1; k--) if (!m_busy[k]) nt = k;
      pa = m_stat[sa]; pb = m_stat[sb];
      m_byp[nt] = 0;
      if (ct != 0 && pa == ct) begin pa = 0; m_byp[nt] = 1; end
      if (ct != 0 && pb == ct) begin pb = 0; m_byp[nt] = 1; end
      if (m_byp[nt]) n_byp++;
      m_wait[nt] = (pa != 0) || (pb != 0);
      m_pa[nt] = pa; m_pb[nt] = pb;
      m_op[nt] = op; m_ga[nt] = g_reg[sa]; m_gb[nt] = g_reg[sb];
      m_res[nt] = alu(op, g_reg[sa], g_reg[sb]);
      g_reg[d] = m_res[nt];
    end

    // Apply the broadcast
    if (ct != 0) begin
      for (int k = 1; k <= NRS; k++) begin
        if (m_busy[k] && m_pa[k] == ct) m_pa[k] = 0;
        if (m_busy[k] && m_pb[k] == ct) m_pb[k] = 0;
      end
      for (int r = 0; r < NREG; r++)
        if (m_stat[r] == ct) begin m_rf[r] = m_res[ct]; m_stat[r] = 0; end
      m_busy[ct] = 0; m_issued[ct] = 0; m_due[ct] = 0;
    end
    if (nt != 0) begin
      m_busy[nt] = 1; m_issued[nt] = 0; m_due[nt] = 0; m_seq[nt] = cyc;
      m_stat[d] = nt;
    end
    rf_raddr = RAW'($urandom);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0421));
    rst_n = 0; disp_valid = 0; disp_op = '0; disp_dst = '0; disp_src_a = '0;
    disp_src_b = '0; cdb_valid = 0; cdb_tag = '0; cdb_value = '0; fu_ready = 0;
    rf_raddr = '0;
    for (int k = 0; k <= NRS; k++) begin
      m_busy[k] = 0; m_issued[k] = 0; m_byp[k] = 0; m_wait[k] = 0; m_seq[k] = 0;
      m_due[k] = 0; m_pa[k] = 0; m_pb[k] = 0; m_op[k] = '0; m_ga[k] = '0;
      m_gb[k] = '0; m_res[k] = '0;
    end
    for (int r = 0; r < NREG; r++) begin m_stat[r] = 0; m_rf[r] = '0; g_reg[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9: reset state
    chk(disp_ready == 1'b1, "R9", "disp_ready after reset", disp_ready, 1);
    chk(issue_valid == 1'b0, "R9", "issue_valid after reset", issue_valid, 0);
    for (int r = 0; r < NREG; r++) begin
      rf_raddr = RAW'(r);
      #1;
      chk(rf_rdata == '0, "R9", "register value after reset", rf_rdata, 0);
      chk(rf_rtag == '0, "R9", "register tag after reset", rf_rtag, 0);
    end
    rf_raddr = '0;

    // Random phases: normal, unit mostly busy (station fills up), unit mostly free
    for (int i = 0; i < 1200; i++) step(60, 80, 1);
    for (int i = 0; i < 1200; i++) step(85, 25, 1);
    for (int i = 0; i < 800; i++)  step(45, 95, 1);

    // Drain
    for (int i = 0; i < 300; i++) begin
      int cnt;
      cnt = 0;
      for (int k = 1; k <= NRS; k++) cnt += int'(m_busy[k]);
      if (cnt == 0) break;
      step(0, 100, 0);
    end
    step(0, 100, 0);
    for (int r = 0; r < NREG; r++) begin
      rf_raddr = RAW'(r);
      #1;
      chk(rf_rdata == g_reg[r], "R8", "final register value", rf_rdata, g_reg[r]);
      chk(rf_rtag == '0, "R3", "final register tag", rf_rtag, 0);
    end

    chk(n_byp > 0, "R5", "same-cycle captures seen", n_byp, 1);
    chk(n_stall > 0, "R1", "dispatch stalls seen", n_stall, 1);
    chk(n_zero > 0, "R10", "zero-tag broadcasts seen", n_zero, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule